// File: doc/BRIEF.md
# Input Port Handshake Receiver

This block sits on the input side of a sequential datapath. It sits between an external producer and the logic that consumes the producer's data. The producer drives a data bus and, when the selected protocol uses one, a valid strobe. The receiver gives the datapath a data word and a one-bit indication that the word may be used. When the selected protocol uses one, it also returns an acknowledge strobe to the producer. The datapath states its demand with a read-request input. Nothing happens until a start input has been seen high.

A static parameter selects one of four port protocols:

- **Full handshake:** valid plus acknowledge. A read stalls until valid arrives, and an acknowledge marks the word taken.
- **Valid-only:** the bus is captured on every valid, whether or not the datapath has asked for it. The word is held until the datapath reads it. A sticky overrun flag records when an unread word is overwritten.
- **Acknowledge-only:** each read is reported by an acknowledge in the same cycle.
- **Plain:** no protocol. The live bus is handed over whenever the datapath reads.

The handshake pins take their names from the data port name plus a suffix (`in_vld_i`, `in_ack_o`). The datapath stalls for as long as it holds read-request high and the ready indication stays low.

Top module: `in_port_rx`

## Requirements
- R1: Before start_i has been sampled high on a rising clock edge, data_ready_o and in_ack_o stay low and no valid is captured. From the cycle after that edge on, operation runs until reset.
- R2: In full-handshake mode, a read request with in_vld_i low leaves data_ready_o and in_ack_o low, so the datapath stalls.
- R3: In full-handshake mode, a read request with in_vld_i high raises data_ready_o and in_ack_o in that same cycle, and rd_data_o equals in_data_i.
- R4: In acknowledge-only mode, in_ack_o and data_ready_o are high in exactly the cycles with a read request, and rd_data_o equals in_data_i.
- R5: In valid-only mode, a cycle with in_vld_i high captures in_data_i whatever rd_req_i is. Any later read request then sees data_ready_o high with that word on rd_data_o. in_ack_o is never driven high in this mode.
- R6: In valid-only mode, a held word is delivered once. After a read with no valid in the same cycle, data_ready_o stays low until a new valid is captured. A valid that arrives in the same cycle as the read replaces the held word.
- R7: In valid-only mode, a valid that arrives while a held word is unread and not being read overwrites it and sets overrun_o. overrun_o stays high until reset.
- R8: In plain mode, data_ready_o follows the read request, in_ack_o stays low, and rd_data_o equals in_data_i.
- R9: The active-low reset clears the held word, the started state, the overrun flag, data_ready_o and in_ack_o.
- R10: in_ack_o is never high in a cycle in which data_ready_o is low. Each acknowledge marks a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Enables operation from the next cycle on |
| rd_req_i | input | 1 | Datapath wants a word in this cycle |
| in_data_i | input | DW | Producer data bus |
| in_vld_i | input | 1 | Producer valid strobe (full-handshake and valid-only modes) |
| in_ack_o | output | 1 | Acknowledge to producer, one pulse per transfer |
| rd_data_o | output | DW | Word for the datapath |
| data_ready_o | output | 1 | rd_data_o is usable in this cycle |
| overrun_o | output | 1 | Sticky: an unread held word was overwritten (valid-only mode) |

## Verification
The ready and acknowledge results respond to rd_req_i and in_vld_i combinationally, within the same cycle. A captured word, the started state and the overrun flag appear only after the next rising edge. The bench applies its inputs just after each rising edge and compares on the falling edge. At that point a reference model, updated at the previous rising edge, gives the expected values for that same cycle. All four modes run side by side on the same stimulus. The checks cover:
- stalls, captures while the datapath is idle, and double valids that overrun;
- reads that fall in the same cycle as a valid;
- activity before start, and a reset in the middle of a run.

// File: rtl/inrx_pkg.sv
package inrx_pkg;
  typedef enum logic [1:0] {
    PM_FULL     = 2'd0,
    PM_VLD_ONLY = 2'd1,
    PM_ACK_ONLY = 2'd2,
    PM_NONE     = 2'd3
  } port_mode_e;
endpackage

// File: rtl/inrx_enable.sv
module inrx_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic run_o
);
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (start_i) run_q <= 1'b1;
  end

  assign run_o = run_q;
endmodule

// File: rtl/inrx_hold.sv
module inrx_hold #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          vld_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          ovr_o
);
  logic [DW-1:0] data_q;
  logic          full_q;
  logic          ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (en_i) begin
      if (vld_i) begin
        data_q <= data_i;
        full_q <= 1'b1;
        // unread word lost
        if (full_q && !take_i) ovr_q <= 1'b1;
      end else if (take_i && full_q) begin
        full_q <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/in_port_rx.sv
module in_port_rx #(
  parameter int unsigned          DW   = 16,
  parameter inrx_pkg::port_mode_e MODE = inrx_pkg::PM_FULL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_req_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_vld_i,
  output logic          in_ack_o,
  output logic [DW-1:0] rd_data_o,
  output logic          data_ready_o,
  output logic          overrun_o
);
  import inrx_pkg::*;

  logic run_q;

  inrx_enable u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .run_o  (run_q)
  );

  generate
    if (MODE == PM_VLD_ONLY) begin : g_vld
      logic [DW-1:0] held;
      logic          full;
      logic          ovr;

      inrx_hold #(.DW(DW)) u_hold (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (run_q),
        .vld_i (in_vld_i),
        .data_i(in_data_i),
        .take_i(rd_req_i),
        .data_o(held),
        .full_o(full),
        .ovr_o (ovr)
      );

      assign data_ready_o = run_q & rd_req_i & full;
      assign rd_data_o    = held;
      assign in_ack_o     = 1'b0;
      assign overrun_o    = ovr;
    end else begin : g_live
      logic fire;

      always_comb begin
        case (MODE)
          PM_FULL: fire = run_q & rd_req_i & in_vld_i;
          default: fire = run_q & rd_req_i;
        endcase
      end

      assign data_ready_o = fire;
      assign rd_data_o    = in_data_i;
      assign in_ack_o     = (MODE != PM_NONE) ? fire : 1'b0;
      assign overrun_o    = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/inrx_checker.sv
module inrx_checker #(
  parameter inrx_pkg::port_mode_e MODE = inrx_pkg::PM_FULL
) (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic rd_req_i,
  input logic in_vld_i,
  input logic in_ack_o,
  input logic data_ready_o,
  input logic overrun_o
);
  import inrx_pkg::*;

  assert_idle_before_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!in_ack_o && !data_ready_o));

  assert_stall_no_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == PM_FULL && rd_req_i && !in_vld_i) |-> (!data_ready_o && !in_ack_o));

  assert_take_with_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == PM_FULL && run_i && rd_req_i && in_vld_i) |-> (data_ready_o && in_ack_o));

  assert_ack_on_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == PM_ACK_ONLY && run_i && rd_req_i) |-> in_ack_o);

  assert_eager_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == PM_VLD_ONLY && run_i && in_vld_i) |=> (!rd_req_i || data_ready_o));

  assert_vld_mode_no_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == PM_VLD_ONLY) |-> !in_ack_o);

  assert_single_delivery_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == PM_VLD_ONLY && data_ready_o && !in_vld_i) |=> !data_ready_o);

  assert_overrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  assert_plain_no_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == PM_NONE) |-> !in_ack_o);

  assert_ack_implies_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o |-> data_ready_o);

  assert_ready_needs_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> rd_req_i);
endmodule

bind in_port_rx inrx_checker #(.MODE(MODE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_q),
  .rd_req_i    (rd_req_i),
  .in_vld_i    (in_vld_i),
  .in_ack_o    (in_ack_o),
  .data_ready_o(data_ready_o),
  .overrun_o   (overrun_o)
);

// File: tb/sim_in_port_rx.sv
`timescale 1ns/1ps
module sim_in_port_rx;
  import inrx_pkg::*;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd_req = 1'b0, vld = 1'b0;
  logic [DW-1:0] data = '0;
  logic [3:0] ack, rdy, ovr;
  logic [DW-1:0] rdat [4];

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  in_port_rx #(.DW(DW), .MODE(PM_FULL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_req_i(rd_req),
    .in_data_i(data), .in_vld_i(vld), .in_ack_o(ack[0]), .rd_data_o(rdat[0]),
    .data_ready_o(rdy[0]), .overrun_o(ovr[0]));
  in_port_rx #(.DW(DW), .MODE(PM_VLD_ONLY)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_req_i(rd_req),
    .in_data_i(data), .in_vld_i(vld), .in_ack_o(ack[1]), .rd_data_o(rdat[1]),
    .data_ready_o(rdy[1]), .overrun_o(ovr[1]));
  in_port_rx #(.DW(DW), .MODE(PM_ACK_ONLY)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_req_i(rd_req),
    .in_data_i(data), .in_vld_i(vld), .in_ack_o(ack[2]), .rd_data_o(rdat[2]),
    .data_ready_o(rdy[2]), .overrun_o(ovr[2]));
  in_port_rx #(.DW(DW), .MODE(PM_NONE)) u3 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_req_i(rd_req),
    .in_data_i(data), .in_vld_i(vld), .in_ack_o(ack[3]), .rd_data_o(rdat[3]),
    .data_ready_o(rdy[3]), .overrun_o(ovr[3]));

  // reference model state
  bit m_run, m_full, m_ovr;
  int m_hold;
  int hq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_full = 0; m_ovr = 0; hq.delete();
    end else begin
      if (m_run && vld) begin
        if (m_full && !rd_req) m_ovr = 1;
        hq.delete(); hq.push_back(int'(data));
        m_full = 1;
      end else if (m_run && rd_req && m_full) begin
        void'(hq.pop_front());
        m_full = 0;
      end
      if (start) m_run = 1;
    end
    m_hold = (hq.size() > 0) ? hq[0] : 0;
  end

  task automatic chk(string tag, int md, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s mode%0d %s: got %0h exp %0h at %0t", tag, md, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < 4; i++) begin
        int e_rdy, e_ack, e_ovr, e_dat;
        string tag;
        e_ovr = 0;
        e_dat = int'(data);
        case (i)
          0: begin
            e_rdy = int'(m_run && rd_req && vld); e_ack = e_rdy;
            tag = !m_run ? "R1" : (rd_req && !vld) ? "R2" : "R3";
          end
          1: begin
            e_rdy = int'(m_run && rd_req && m_full); e_ack = 0;
            e_ovr = int'(m_ovr); e_dat = m_hold;
            tag = !m_run ? "R1" : m_ovr ? "R7" : m_full ? "R5" : "R6";
          end
          2: begin
            e_rdy = int'(m_run && rd_req); e_ack = e_rdy;
            tag = !m_run ? "R1" : "R4";
          end
          default: begin
            e_rdy = int'(m_run && rd_req); e_ack = 0;
            tag = !m_run ? "R1" : "R8";
          end
        endcase
        if (!rst_n) tag = "R9";
        chk(tag, i, "ready", int'(rdy[i]), e_rdy);
        chk(tag, i, "ack", int'(ack[i]), e_ack);
        chk(tag, i, "overrun", int'(ovr[i]), e_ovr);
        if (e_rdy != 0) chk(tag, i, "data", int'(rdat[i]), e_dat);
        if (ack[i] && !rdy[i]) chk("R10", i, "ack_without_ready", 1, 0);
      end
    end
  end

  task automatic drive(bit s, bit r, bit v, logic [DW-1:0] d);
    @(posedge clk); #1;
    start = s; rd_req = r; vld = v; data = d;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lfsr;
    lfsr = 32'h1d2c_3b4a;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state at the ports
    chk("R9", 0, "ready_in_reset", int'(|rdy), 0);
    chk("R9", 0, "ack_in_reset", int'(|ack), 0);
    rst_n = 1;
    // R1: activity before start is ignored
    drive(0, 1, 1, 8'h11);
    drive(0, 0, 1, 8'h22);
    drive(0, 1, 0, 8'h33);
    drive(1, 0, 0, 8'h00);
    // R2 stall, then R3 take
    drive(0, 1, 0, 8'h44);
    drive(0, 1, 0, 8'h45);
    drive(0, 1, 1, 8'h46);
    // R5 eager capture while idle, read later
    drive(0, 0, 1, 8'h5a);
    drive(0, 0, 0, 8'h00);
    drive(0, 1, 0, 8'h01);
    // R6: no second delivery
    drive(0, 1, 0, 8'h02);
    // R6: valid in same cycle as read replaces the word
    drive(0, 0, 1, 8'h61);
    drive(0, 1, 1, 8'h62);
    drive(0, 1, 0, 8'h00);
    // R7: double valid without a read
    drive(0, 0, 1, 8'h71);
    drive(0, 0, 1, 8'h72);
    drive(0, 1, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    // mixed traffic, R4 / R8 / R10 exercised throughout
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(0, lfsr[3], lfsr[7], lfsr[15:8]);
    end
    // R9: reset mid-run clears the held word, the overrun flag and the started state
    @(posedge clk); #1;
    rst_n = 0;
    @(posedge clk); #1;
    rst_n = 1;
    drive(0, 1, 1, 8'h91);
    drive(1, 1, 0, 8'h92);
    drive(0, 1, 0, 8'h93);
    drive(0, 1, 1, 8'h94);
    drive(0, 0, 0, 8'h00);
    @(posedge clk); #1;
    finish_run();
  end
endmodule